// File: doc/BRIEF.md
# Parallel Flash Port Strobe Controller

This block lets a CPU talk to an external parallel flash device through two general-purpose I/O ports. The CPU reaches five byte registers over a small access bus: the two port output registers, their two direction registers and a control register. While the control register's enable bit is clear, both ports behave as plain GPIO. Once it is set, the 8-bit first port becomes the flash data bus, and the three low pins of the second port are driven as output-enable, write-enable and a strobe line. Every CPU read or write of the data port then produces strobe pulses one clock cycle long, shaped by two control bits.

The access bus uses a valid/ready handshake. An access is taken on a rising edge where `bus_valid` and `bus_ready` are both high. `bus_ready` drops for exactly the one cycle after each accepted access, which is the cycle in which any strobe pulse is driven. This keeps consecutive flash accesses from merging their pulses. While `bus_ready` is low, the requester must hold its request stable. Read data is combinational and is valid in the cycle in which the read is accepted.

Top module: `flash_port_strobe`

## Requirements
- R1: After reset, all registers read 0, `p0_oe`, `p1_out` and `p1_oe` are all zero, and `bus_ready` is 1.
- R2: With the enable bit (control bit 7) at 0, an access to the data port (address 0) produces no strobe, and the second port's pins follow its output register (address 1) and direction register (address 3). With the enable bit at 1, pins 0, 1 and 2 of the second port are outputs carrying output-enable, write-enable and strobe, in that order.
- R3: While enabled with the OE bit (control bit 5) at 1, each accepted read of address 0 drives `p1_out[0]` low for exactly the following cycle, and it is high otherwise. With the OE bit at 0, `p1_out[0]` stays low.
- R4: While enabled with the WE bit (control bit 6) at 1, each accepted write of address 0 drives `p1_out[1]` low for exactly the following cycle. With the WE bit at 0, `p1_out[1]` stays high.
- R5: While enabled with OE=1 and WE=0, each accepted write of address 0 drives `p1_out[2]` high for exactly the following cycle.
- R6: While enabled with OE=0 and WE=1, each accepted read of address 0 drives `p1_out[2]` high for exactly the following cycle.
- R7: While enabled with OE and WE equal, `p1_out[2]` stays low.
- R8: `p0_oe` always equals the first port's direction register (address 2), whatever the enable state. A read of address 0 returns the output register on bits whose direction bit is set and `p0_in` on the other bits.
- R9: The control register (address 4) stores only bits 7, 6, 5 and 0. Bits 1 to 4 always read as 0.
- R10: A read of address 1 returns the output register on pins whose direction bit is set. On input pins it returns `p1_in` when control bit 0 is 0 and the output register when it is 1.
- R11: `bus_ready` is low in the cycle after every accepted access and high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Access request |
| bus_ready | output | 1 | Access may be taken this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address (0..4) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the accepting cycle |
| p0_in | input | 8 | First port pin levels |
| p0_out | output | 8 | First port output drive |
| p0_oe | output | 8 | First port per-pin output enable |
| p1_in | input | 3 | Second port pin levels |
| p1_out | output | 3 | Second port output drive |
| p1_oe | output | 3 | Second port per-pin output enable |

## Verification
The strobe generator and the handshake act in the same cycle. The cycle in which a pulse is on a pin is also the cycle in which `bus_ready` is withdrawn. The bench issues flash reads and writes under each of the four control-bit combinations. It checks the pin triple in the pulse cycle and again one cycle later, and it reads `bus_ready` in that same pulse cycle. This confirms that every pulse lasts one cycle and that no new access can overlap it. A further case that falls together is a control-register write followed at once by a data access. The bench expects that access to be shaped by the new settings.

// File: rtl/fps_pkg.sv
package fps_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_P0_DAT = 3'd0,
    A_P1_DAT = 3'd1,
    A_P0_DIR = 3'd2,
    A_P1_DIR = 3'd3,
    A_CTRL   = 3'd4
  } reg_addr_e;

  localparam int B_RDSEL = 0;
  localparam int B_OECTL = 5;
  localparam int B_WECTL = 6;
  localparam int B_EN    = 7;

  typedef struct packed {
    logic en;
    logic we_ctl;
    logic oe_ctl;
    logic rdsel;
  } ctrl_t;
endpackage

// File: rtl/fps_regs.sv
module fps_regs
  import fps_pkg::*;
#(
  parameter int P1_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] p0_dat,
  output logic [DATA_W-1:0] p0_dir,
  output logic [P1_W-1:0]   p1_dat,
  output logic [P1_W-1:0]   p1_dir,
  output ctrl_t             ctrl
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p0_dat <= '0;
      p0_dir <= '0;
      p1_dat <= '0;
      p1_dir <= '0;
      ctrl   <= '0;
    end else if (wr_en) begin
      unique case (addr)
        A_P0_DAT: p0_dat <= wdata;
        A_P0_DIR: p0_dir <= wdata;
        A_P1_DAT: p1_dat <= wdata[P1_W-1:0];
        A_P1_DIR: p1_dir <= wdata[P1_W-1:0];
        A_CTRL: begin
          ctrl.en     <= wdata[B_EN];
          ctrl.we_ctl <= wdata[B_WECTL];
          ctrl.oe_ctl <= wdata[B_OECTL];
          ctrl.rdsel  <= wdata[B_RDSEL];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fps_strobe.sv
module fps_strobe
  import fps_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  flash_acc,
  input  logic  acc_wr,
  input  ctrl_t ctrl,
  output logic  oe_pin,
  output logic  we_pin,
  output logic  sc_pin
);
  logic oe_p, we_p, sc_p;

  // Pulse kinds are latched with the settings in force at the access,
  // so each lasts one full cycle whatever happens to the control bits.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_p <= 1'b0;
      we_p <= 1'b0;
      sc_p <= 1'b0;
    end else begin
      oe_p <= flash_acc & ~acc_wr & ctrl.oe_ctl;
      we_p <= flash_acc &  acc_wr & ctrl.we_ctl;
      sc_p <= flash_acc & ( (acc_wr  & ctrl.oe_ctl & ~ctrl.we_ctl)
                          | (~acc_wr & ~ctrl.oe_ctl & ctrl.we_ctl));
    end
  end

  assign oe_pin = ctrl.oe_ctl & ~oe_p;
  assign we_pin = ~we_p;
  assign sc_pin = sc_p;
endmodule

// File: rtl/fps_pinmux.sv
module fps_pinmux
  import fps_pkg::*;
#(
  parameter int P1_W = 3
) (
  input  ctrl_t             ctrl,
  input  logic              oe_pin,
  input  logic              we_pin,
  input  logic              sc_pin,
  input  logic [DATA_W-1:0] p0_dat,
  input  logic [DATA_W-1:0] p0_dir,
  input  logic [P1_W-1:0]   p1_dat,
  input  logic [P1_W-1:0]   p1_dir,
  input  logic [DATA_W-1:0] p0_in,
  input  logic [P1_W-1:0]   p1_in,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] p0_out,
  output logic [DATA_W-1:0] p0_oe,
  output logic [P1_W-1:0]   p1_out,
  output logic [P1_W-1:0]   p1_oe,
  output logic [DATA_W-1:0] rdata
);
  localparam int N_STB = 3;
  logic [N_STB-1:0] stb;
  logic [P1_W-1:0]  p1_rb;
  logic [DATA_W-1:0] p0_rb;

  assign stb    = {sc_pin, we_pin, oe_pin};
  assign p0_out = p0_dat;
  assign p0_oe  = p0_dir;
  assign p0_rb  = (p0_dat & p0_dir) | (p0_in & ~p0_dir);

  for (genvar i = 0; i < P1_W; i++) begin : g_p1
    if (i < N_STB) begin : g_stb
      assign p1_out[i] = ctrl.en ? stb[i] : p1_dat[i];
      assign p1_oe[i]  = ctrl.en | p1_dir[i];
    end else begin : g_gpio
      assign p1_out[i] = p1_dat[i];
      assign p1_oe[i]  = p1_dir[i];
    end
    assign p1_rb[i] = (p1_dir[i] | ctrl.rdsel) ? p1_dat[i] : p1_in[i];
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_P0_DAT: rdata = p0_rb;
      A_P0_DIR: rdata = p0_dir;
      A_P1_DAT: rdata[P1_W-1:0] = p1_rb;
      A_P1_DIR: rdata[P1_W-1:0] = p1_dir;
      A_CTRL: begin
        rdata[B_EN]    = ctrl.en;
        rdata[B_WECTL] = ctrl.we_ctl;
        rdata[B_OECTL] = ctrl.oe_ctl;
        rdata[B_RDSEL] = ctrl.rdsel;
      end
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/flash_port_strobe.sv
module flash_port_strobe
  import fps_pkg::*;
#(
  parameter int P1_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] p0_in,
  output logic [DATA_W-1:0] p0_out,
  output logic [DATA_W-1:0] p0_oe,
  input  logic [P1_W-1:0]   p1_in,
  output logic [P1_W-1:0]   p1_out,
  output logic [P1_W-1:0]   p1_oe
);
  logic              take, busy_q, flash_acc;
  logic [DATA_W-1:0] p0_dat, p0_dir;
  logic [P1_W-1:0]   p1_dat, p1_dir;
  ctrl_t             ctrl_q;
  logic              oe_pin, we_pin, sc_pin;

  assign take      = bus_valid & bus_ready;
  assign bus_ready = ~busy_q;
  assign flash_acc = take & ctrl_q.en & (bus_addr == A_P0_DAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= take;
  end

  fps_regs #(.P1_W(P1_W)) i_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(take & bus_write), .addr(bus_addr),
    .wdata(bus_wdata), .p0_dat(p0_dat), .p0_dir(p0_dir), .p1_dat(p1_dat),
    .p1_dir(p1_dir), .ctrl(ctrl_q)
  );

  fps_strobe i_strobe (
    .clk(clk), .rst_n(rst_n), .flash_acc(flash_acc), .acc_wr(bus_write),
    .ctrl(ctrl_q), .oe_pin(oe_pin), .we_pin(we_pin), .sc_pin(sc_pin)
  );

  fps_pinmux #(.P1_W(P1_W)) i_pinmux (
    .ctrl(ctrl_q), .oe_pin(oe_pin), .we_pin(we_pin), .sc_pin(sc_pin),
    .p0_dat(p0_dat), .p0_dir(p0_dir), .p1_dat(p1_dat), .p1_dir(p1_dir),
    .p0_in(p0_in), .p1_in(p1_in), .addr(bus_addr), .p0_out(p0_out),
    .p0_oe(p0_oe), .p1_out(p1_out), .p1_oe(p1_oe), .rdata(bus_rdata)
  );
endmodule

// File: rtl/fps_checker.sv
module fps_checker
  import fps_pkg::*;
#(
  parameter int P1_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_ready,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [P1_W-1:0]   p1_out,
  input ctrl_t             ctrl_q
);
  logic rd_acc, wr_acc;
  assign rd_acc = bus_valid & bus_ready & ~bus_write & ctrl_q.en & (bus_addr == A_P0_DAT);
  assign wr_acc = bus_valid & bus_ready &  bus_write & ctrl_q.en & (bus_addr == A_P0_DAT);

  a_r3_oe_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && ctrl_q.oe_ctl) |=> !p1_out[0]);
  a_r4_we_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && ctrl_q.we_ctl) |=> !p1_out[1]);
  a_r5_sc_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && ctrl_q.oe_ctl && !ctrl_q.we_ctl) |=> p1_out[2]);
  a_r6_sc_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && !ctrl_q.oe_ctl && ctrl_q.we_ctl) |=> p1_out[2]);
  a_r7_sc_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.en && (ctrl_q.oe_ctl == ctrl_q.we_ctl)) |-> !p1_out[2]);
  a_r11_ready_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_ready) |=> !bus_ready);
endmodule

bind flash_port_strobe fps_checker #(.P1_W(P1_W)) i_fps_checker (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
  .bus_write(bus_write), .bus_addr(bus_addr), .p1_out(p1_out), .ctrl_q(ctrl_q)
);

// File: tb/test_flash_port_strobe.sv
module test_flash_port_strobe;
  localparam int PERIOD = 10;
  localparam int NV = 26;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_valid = 1'b0, bus_write = 1'b0;
  logic       bus_ready;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [7:0] p0_in = 8'hA5, p0_out, p0_oe;
  logic [2:0] p1_in = 3'b010, p1_out, p1_oe;
  int total = 0, bad = 0;

  always #(PERIOD/2) clk = ~clk;

  flash_port_strobe i_flash_port_strobe (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .p0_in(p0_in), .p0_out(p0_out), .p0_oe(p0_oe),
    .p1_in(p1_in), .p1_out(p1_out), .p1_oe(p1_oe)
  );

  // {write, addr, wdata, pins in pulse cycle {sc,we,oe}, pins a cycle later, read data}
  localparam logic [25:0] VEC [NV] = '{
    {1'b0, 3'd4, 8'h00, 3'b000, 3'b000, 8'h00}, // R1 control reads 0
    {1'b1, 3'd1, 8'h05, 3'b101, 3'b101, 8'h00}, // R2 gpio drive
    {1'b1, 3'd3, 8'h02, 3'b101, 3'b101, 8'h00},
    {1'b0, 3'd1, 8'h00, 3'b101, 3'b101, 8'h00}, // R10 pin levels
    {1'b0, 3'd0, 8'h00, 3'b101, 3'b101, 8'hA5}, // R2 R8 no strobe
    {1'b1, 3'd0, 8'h3C, 3'b101, 3'b101, 8'h00},
    {1'b1, 3'd4, 8'h01, 3'b101, 3'b101, 8'h00},
    {1'b0, 3'd4, 8'h00, 3'b101, 3'b101, 8'h01},
    {1'b0, 3'd1, 8'h00, 3'b101, 3'b101, 8'h05}, // R10 register levels
    {1'b1, 3'd4, 8'hFF, 3'b011, 3'b011, 8'h00}, // R9 R7
    {1'b0, 3'd4, 8'h00, 3'b011, 3'b011, 8'hE1},
    {1'b0, 3'd0, 8'h00, 3'b010, 3'b011, 8'hA5}, // R3
    {1'b1, 3'd0, 8'h5A, 3'b001, 3'b011, 8'h00}, // R4
    {1'b1, 3'd4, 8'hA0, 3'b011, 3'b011, 8'h00},
    {1'b1, 3'd0, 8'h11, 3'b111, 3'b011, 8'h00}, // R5
    {1'b0, 3'd0, 8'h00, 3'b010, 3'b011, 8'hA5}, // R3
    {1'b1, 3'd4, 8'hC0, 3'b010, 3'b010, 8'h00},
    {1'b0, 3'd0, 8'h00, 3'b110, 3'b010, 8'hA5}, // R6
    {1'b1, 3'd0, 8'h22, 3'b000, 3'b010, 8'h00}, // R4
    {1'b1, 3'd4, 8'h80, 3'b010, 3'b010, 8'h00},
    {1'b0, 3'd0, 8'h00, 3'b010, 3'b010, 8'hA5}, // R7
    {1'b1, 3'd0, 8'h77, 3'b010, 3'b010, 8'h00},
    {1'b1, 3'd2, 8'hF0, 3'b010, 3'b010, 8'h00},
    {1'b0, 3'd0, 8'h00, 3'b010, 3'b010, 8'h75}, // R8 mixed read-back
    {1'b1, 3'd4, 8'h1E, 3'b101, 3'b101, 8'h00}, // R9 unused bits
    {1'b0, 3'd4, 8'h00, 3'b101, 3'b101, 8'h00}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [2:0] a, input logic [7:0] d,
                        output logic [7:0] rd);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
    #1 rd = bus_rdata;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  initial begin
    #(PERIOD * 20000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 p1_out", {5'b0, p1_out}, 8'h00);
    chk("R1 p1_oe", {5'b0, p1_oe}, 8'h00);
    chk("R1 p0_oe", p0_oe, 8'h00);
    chk("R1 bus_ready", {7'b0, bus_ready}, 8'h01);

    for (int k = 0; k < NV; k++) begin
      logic [25:0] v;
      v = VEC[k];
      access(v[25], v[24:22], v[21:14], rd);
      chk("R2 R3 R4 R5 R6 R7 pins in pulse cycle", {5'b0, p1_out}, {5'b0, v[13:11]});
      chk("R11 ready low after access", {7'b0, bus_ready}, 8'h00);
      if (!v[25]) chk("R8 R9 R10 read data", rd, v[7:0]);
      @(negedge clk);
      chk("R3 R4 R5 R6 pulse one cycle", {5'b0, p1_out}, {5'b0, v[10:8]});
      chk("R11 ready back", {7'b0, bus_ready}, 8'h01);
    end

    // Directed: enabled port directions
    access(1'b1, 3'd4, 8'hE0, rd);
    chk("R8 p0_oe follows direction when enabled", p0_oe, 8'hF0);
    chk("R2 strobe pins forced to output", {5'b0, p1_oe}, 8'h07);
    chk("R8 p0_out holds register", p0_out, 8'h77);
    // Directed: control write then immediate data read uses new settings
    access(1'b1, 3'd4, 8'hC0, rd);
    @(negedge clk);
    access(1'b0, 3'd0, 8'h00, rd);
    chk("R6 new settings on next access", {5'b0, p1_out}, 8'h06);
    access(1'b1, 3'd4, 8'h00, rd);
    chk("R2 gpio restored", {5'b0, p1_oe}, 8'h02);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule